// File: doc/BRIEF.md
# Masked Grouped Fast-OR Trigger with Per-Channel Rate Counters

This block sits behind a bank of eighteen discriminators. It brings every discriminator output into the system clock domain, suppresses the channels that a mask register marks as noisy, and raises two trigger proposals. The low proposal covers inputs 8..0, which come from one detector plane. The high proposal covers inputs 17..9, which come from the other plane. Each proposal is the OR of its nine unmasked inputs.

Alongside the triggers, the block counts the hits on every channel over a repeating time window whose length is set by a 2-bit code. At the end of each window it latches all eighteen counts into a snapshot store, which can be read back one channel at a time by index. A monitor output follows any one synchronized input chosen by a channel-select register, so a single channel can be watched on a scope or by downstream logic.

The mask, the window code, the monitor index and the read index are plain register-style inputs. A one-cycle strobe marks the moment each new snapshot is latched.

Top module: `hit_trigger_unit`

## Requirements
- R1: Every input passes through two synchronizing flip-flops, and both trigger outputs are registered. A change on an input therefore appears on a trigger output after the third rising clock edge, and not before it.
- R2: `trig_lo` is high when any unmasked input among bits 8..0 is high. `trig_hi` is high when any unmasked input among bits 17..9 is high. An input in one group never drives the other group's output.
- R3: When mask bit i is 1, input i takes no part in its group's OR and adds nothing to its hit count.
- R4: A hit is one rising edge of a synchronized, unmasked input. Each channel has its own count, and a steady high level adds no further hits.
- R5: Window code 0, 1, 2 and 3 select windows of WIN0, WIN1, WIN2 and WIN3 clock cycles. `win_tick` is high for exactly one cycle at the end of each window, so with a fixed code consecutive ticks are exactly one window width apart.
- R6: A running count stops at 2^CNT_W-1 and does not wrap.
- R7: In the cycle where `win_tick` rises, the snapshot takes the running counts of the window just ended. The running counts then restart from zero. A rising edge seen in that same cycle counts as the first hit of the new window.
- R8: A change of the window code restarts the window timer and discards the running counts without producing a snapshot. Hits seen before the change are therefore never reported.
- R9: `rd_count` shows the snapshot of channel `rd_idx` one clock after the index is presented. An index of 18 or more reads as 0.
- R10: `mon_out` follows the synchronized input selected by `mon_sel`, ignores the mask, and has the same latency as the triggers. An index of 18 or more gives 0.
- R11: While `rst` is high and right after it is released, both triggers, `mon_out`, `win_tick` and `rd_count` are 0, and every snapshot entry is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_in | input | 18 | Asynchronous discriminator outputs; bits 8..0 from the first plane, bits 17..9 from the second |
| mask | input | 18 | 1 removes the channel from its trigger OR and from counting |
| win_sel | input | 2 | Window width code, 0..3 |
| mon_sel | input | 5 | Channel routed to `mon_out` |
| rd_idx | input | 5 | Channel whose snapshot appears on `rd_count` |
| trig_lo | output | 1 | Registered OR of unmasked inputs 8..0 |
| trig_hi | output | 1 | Registered OR of unmasked inputs 17..9 |
| mon_out | output | 1 | Registered selected synchronized input |
| win_tick | output | 1 | One-cycle pulse when a window closes and its snapshot is latched |
| rd_count | output | CNT_W | Snapshot hit count of channel `rd_idx` |

## Verification
The bench builds the block with window widths of 20, 40, 80 and 160 cycles in place of the millisecond-scale defaults. With these widths, every window code, the tick period and the restart on a code change can all be measured within a few hundred cycles. The counter width is set to 4 bits, so saturation at 15 is reached with a burst of twenty pulses inside one 160-cycle window, and the same burst shows that the count does not wrap. Default widths are left to elaboration only.

// File: rtl/htu_pkg.sv
package htu_pkg;

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  typedef enum logic [1:0] {
    WIN_CODE_0 = 2'd0,
    WIN_CODE_1 = 2'd1,
    WIN_CODE_2 = 2'd2,
    WIN_CODE_3 = 2'd3
  } win_code_e;

endpackage

// File: rtl/htu_sync.sv
module htu_sync #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1[i] <= 1'b0;
        q[i]      <= 1'b0;
      end else begin
        stage1[i] <= d[i];
        q[i]      <= stage1[i];
      end
    end
  end
endmodule

// File: rtl/htu_window.sv
module htu_window
  import htu_pkg::*;
#(
  parameter int unsigned WIN0 = 10_000,
  parameter int unsigned WIN1 = 100_000,
  parameter int unsigned WIN2 = 1_000_000,
  parameter int unsigned WIN3 = 10_000_000,
  localparam int unsigned WMAX = max_of4(WIN0, WIN1, WIN2, WIN3),
  localparam int CW = $clog2(WMAX + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] win_sel,
  output logic       win_end,
  output logic       restart
);
  win_code_e     sel_q;
  logic [CW-1:0] wcnt;
  logic [CW-1:0] width_m1;

  always_comb begin
    unique case (sel_q)
      WIN_CODE_0: width_m1 = CW'(WIN0 - 1);
      WIN_CODE_1: width_m1 = CW'(WIN1 - 1);
      WIN_CODE_2: width_m1 = CW'(WIN2 - 1);
      default:    width_m1 = CW'(WIN3 - 1);
    endcase
  end

  assign restart = (win_code_e'(win_sel) != sel_q);
  assign win_end = !restart && (wcnt == width_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= WIN_CODE_0;
      wcnt  <= '0;
    end else begin
      sel_q <= win_code_e'(win_sel);
      if (restart || win_end) wcnt <= '0;
      else                    wcnt <= wcnt + 1'b1;
    end
  end
endmodule

// File: rtl/htu_trigger.sv
module htu_trigger #(
  parameter int N_CH = 18,
  parameter int GRP  = 9,
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CH-1:0]  sync_in,
  input  logic [N_CH-1:0]  mask,
  input  logic [IDX_W-1:0] mon_sel,
  output logic             trig_lo,
  output logic             trig_hi,
  output logic             mon_out
);
  logic [N_CH-1:0] live;
  assign live = sync_in & ~mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_lo <= 1'b0;
      trig_hi <= 1'b0;
      mon_out <= 1'b0;
    end else begin
      trig_lo <= |live[GRP-1:0];
      trig_hi <= |live[N_CH-1:GRP];
      mon_out <= (32'(mon_sel) < N_CH) ? sync_in[mon_sel] : 1'b0;
    end
  end
endmodule

// File: rtl/htu_rate_bank.sv
module htu_rate_bank #(
  parameter int N_CH  = 18,
  parameter int CNT_W = 16,
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_CH-1:0]         sync_in,
  input  logic [N_CH-1:0]         mask,
  input  logic                    win_end,
  input  logic                    restart,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [CNT_W-1:0]        rd_count,
  output logic                    win_tick,
  output logic [N_CH*CNT_W-1:0]   live_cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [N_CH-1:0]  prev;
  logic [CNT_W-1:0] snap_mem [N_CH];

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic [CNT_W-1:0] cnt;
    logic             rise;

    assign rise = sync_in[i] & ~prev[i] & ~mask[i];
    assign live_cnt[i*CNT_W +: CNT_W] = cnt;

    always_ff @(posedge clk) begin
      if (rst) begin
        prev[i] <= 1'b0;
        cnt     <= '0;
      end else begin
        prev[i] <= sync_in[i];
        if (restart)                 cnt <= '0;
        else if (win_end)            cnt <= {{(CNT_W-1){1'b0}}, rise};
        else if (rise && cnt != CMAX) cnt <= cnt + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst)          snap_mem[i] <= '0;
      else if (win_end) snap_mem[i] <= cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_count <= '0;
      win_tick <= 1'b0;
    end else begin
      rd_count <= (32'(rd_idx) < N_CH) ? snap_mem[rd_idx] : '0;
      win_tick <= win_end;
    end
  end
endmodule

// File: rtl/hit_trigger_unit.sv
module hit_trigger_unit #(
  parameter int unsigned WIN0  = 10_000,
  parameter int unsigned WIN1  = 100_000,
  parameter int unsigned WIN2  = 1_000_000,
  parameter int unsigned WIN3  = 10_000_000,
  parameter int          CNT_W = 16,
  parameter int          N_CH  = 18,
  localparam int GRP   = N_CH / 2,
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CH-1:0]  hit_in,
  input  logic [N_CH-1:0]  mask,
  input  logic [1:0]       win_sel,
  input  logic [IDX_W-1:0] mon_sel,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             trig_lo,
  output logic             trig_hi,
  output logic             mon_out,
  output logic             win_tick,
  output logic [CNT_W-1:0] rd_count
);
  logic [N_CH-1:0]       sync_q;
  logic                  win_end;
  logic                  win_restart;
  logic [N_CH*CNT_W-1:0] live_cnt;

  htu_sync #(.WIDTH(N_CH)) u_sync (
    .clk(clk), .rst(rst), .d(hit_in), .q(sync_q)
  );

  htu_window #(.WIN0(WIN0), .WIN1(WIN1), .WIN2(WIN2), .WIN3(WIN3)) u_win (
    .clk(clk), .rst(rst), .win_sel(win_sel), .win_end(win_end), .restart(win_restart)
  );

  htu_trigger #(.N_CH(N_CH), .GRP(GRP)) u_trig (
    .clk(clk), .rst(rst), .sync_in(sync_q), .mask(mask), .mon_sel(mon_sel),
    .trig_lo(trig_lo), .trig_hi(trig_hi), .mon_out(mon_out)
  );

  htu_rate_bank #(.N_CH(N_CH), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst(rst), .sync_in(sync_q), .mask(mask),
    .win_end(win_end), .restart(win_restart), .rd_idx(rd_idx),
    .rd_count(rd_count), .win_tick(win_tick), .live_cnt(live_cnt)
  );
endmodule

// File: rtl/htu_check.sv
module htu_check #(
  parameter int N_CH  = 18,
  parameter int CNT_W = 16,
  localparam int GRP   = N_CH / 2,
  localparam int IDX_W = $clog2(N_CH)
) (
  input logic                  clk,
  input logic                  rst,
  input logic [N_CH-1:0]       hit_in,
  input logic [N_CH-1:0]       mask,
  input logic                  trig_lo,
  input logic                  trig_hi,
  input logic                  win_tick,
  input logic [IDX_W-1:0]      rd_idx,
  input logic [CNT_W-1:0]      rd_count,
  input logic                  restart,
  input logic [N_CH*CNT_W-1:0] live_cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  // R1 / R2: a trigger needs some input of its own group high three edges back
  p_lo_cause_r1: assert property (@(posedge clk) disable iff (rst)
    trig_lo |-> $past(|hit_in[GRP-1:0], 3));
  p_hi_cause_r2: assert property (@(posedge clk) disable iff (rst)
    trig_hi |-> $past(|hit_in[N_CH-1:GRP], 3));

  // R5: the window end strobe lasts a single cycle
  p_tick_single_r5: assert property (@(posedge clk) disable iff (rst)
    win_tick |=> !win_tick);

  // R9: an index past the last channel reads as zero
  p_rd_oor_r9: assert property (@(posedge clk) disable iff (rst)
    (32'(rd_idx) >= N_CH) |=> (rd_count == '0));

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic [CNT_W-1:0] c;
    assign c = live_cnt[i*CNT_W +: CNT_W];

    // R3: a masked channel's running count never grows
    p_masked_hold_r3: assert property (@(posedge clk) disable iff (rst)
      mask[i] |=> (c == $past(c)) || (c == '0));

    // R6: a saturated count stays put until a window closes or restarts
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
      (c == CMAX) |=> (c == CMAX) || win_tick || $past(restart));
  end
endmodule

bind hit_trigger_unit htu_check #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .hit_in(hit_in), .mask(mask),
  .trig_lo(trig_lo), .trig_hi(trig_hi), .win_tick(win_tick),
  .rd_idx(rd_idx), .rd_count(rd_count), .restart(win_restart), .live_cnt(live_cnt)
);

// File: tb/hit_trigger_unit_test.sv
module hit_trigger_unit_test;
  localparam int W0 = 20, W1 = 40, W2 = 80, W3 = 160;
  localparam int CW = 4;
  localparam int NC = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NC-1:0] hit_in = '0;
  logic [NC-1:0] mask = '0;
  logic [1:0]    win_sel = 2'd0;
  logic [4:0]    mon_sel = '0;
  logic [4:0]    rd_idx = '0;
  logic          trig_lo, trig_hi, mon_out, win_tick;
  logic [CW-1:0] rd_count;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  hit_trigger_unit #(.WIN0(W0), .WIN1(W1), .WIN2(W2), .WIN3(W3), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .hit_in(hit_in), .mask(mask), .win_sel(win_sel),
    .mon_sel(mon_sel), .rd_idx(rd_idx), .trig_lo(trig_lo), .trig_hi(trig_hi),
    .mon_out(mon_out), .win_tick(win_tick), .rd_count(rd_count)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!win_tick);
  endtask

  task automatic pulses(input logic [NC-1:0] bits, input int n);
    for (int k = 0; k < n; k++) begin
      hit_in = bits; edges(2);
      hit_in = '0;   edges(2);
    end
  endtask

  task automatic read_ch(input int ch, input string req, input int exp);
    rd_idx = 5'(ch); edges(1);
    check(req, int'(rd_count), exp);
  endtask

  task automatic t_reset();
    edges(1);
    check("R11 trig_lo", int'(trig_lo), 0);
    check("R11 trig_hi", int'(trig_hi), 0);
    check("R11 mon_out", int'(mon_out), 0);
    check("R11 win_tick", int'(win_tick), 0);
    rd_idx = 5'd7; edges(1);
    check("R11 snapshot", int'(rd_count), 0);
  endtask

  task automatic t_trigger();
    hit_in = 18'(1) << 4; edges(2);
    check("R1 no early trig_lo", int'(trig_lo), 0);
    edges(1);
    check("R1 trig_lo third edge", int'(trig_lo), 1);
    check("R2 trig_hi idle for low group", int'(trig_hi), 0);
    hit_in = 18'(1) << 15; edges(3);
    check("R2 trig_hi", int'(trig_hi), 1);
    check("R2 trig_lo idle for high group", int'(trig_lo), 0);
    hit_in = '0; edges(3);
    check("R2 trig_hi clears", int'(trig_hi), 0);
  endtask

  task automatic t_mask();
    mask = (18'(1) << 3) | (18'(1) << 12);
    hit_in = 18'(1) << 3; edges(3);
    check("R3 masked low input", int'(trig_lo), 0);
    hit_in = 18'(1) << 12; edges(3);
    check("R3 masked high input", int'(trig_hi), 0);
    hit_in = '0;
    win_sel = 2'd2; wait_tick();
    pulses((18'(1) << 3) | (18'(1) << 4), 5);
    wait_tick();
    read_ch(3, "R3 masked count", 0);
    read_ch(4, "R4 neighbour count", 5);
    mask = '0;
  endtask

  task automatic t_count();
    win_sel = 2'd2; wait_tick();
    pulses(18'(1) << 0, 7);
    hit_in = 18'(1) << 17; edges(20);
    wait_tick();
    hit_in = '0;
    read_ch(0, "R4 R7 count ch0", 7);
    read_ch(17, "R4 steady level one hit", 1);
    read_ch(9, "R4 quiet channel", 0);
  endtask

  task automatic t_saturate();
    win_sel = 2'd3; wait_tick(); wait_tick();
    pulses(18'(1) << 10, 20);
    wait_tick();
    read_ch(10, "R6 saturated count", 15);
  endtask

  task automatic t_window();
    for (int c = 0; c < 4; c++) begin
      int n;
      int exp;
      exp = (c == 0) ? W0 : (c == 1) ? W1 : (c == 2) ? W2 : W3;
      win_sel = 2'(c);
      wait_tick();
      n = 0;
      do begin @(negedge clk); n++; end while (!win_tick);
      check($sformatf("R5 period code %0d", c), n, exp);
    end
  endtask

  task automatic t_restart();
    win_sel = 2'd2; wait_tick();
    pulses(18'(1) << 6, 5);
    win_sel = 2'd1;
    wait_tick();
    read_ch(6, "R8 counts discarded", 0);
  endtask

  task automatic t_read_range();
    read_ch(20, "R9 out of range index", 0);
    read_ch(31, "R9 top index", 0);
  endtask

  task automatic t_monitor();
    mon_sel = 5'd5; mask = 18'(1) << 5;
    hit_in = 18'(1) << 5; edges(3);
    check("R10 monitor ignores mask", int'(mon_out), 1);
    hit_in = ~(18'(1) << 5); edges(3);
    check("R10 monitor other channels", int'(mon_out), 0);
    mon_sel = 5'd16; edges(2);
    check("R10 monitor ch16", int'(mon_out), 1);
    mon_sel = 5'd22; edges(2);
    check("R10 monitor out of range", int'(mon_out), 0);
    hit_in = '0; mask = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_trigger();
    t_mask();
    t_count();
    t_saturate();
    t_window();
    t_restart();
    t_read_range();
    t_monitor();
    finish_run();
  end

  initial begin
    #(20 * 100_000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    finish_run();
  end
endmodule